// File: doc/BRIEF.md
# FEC error pattern trimmer

This block sits behind the Reed-Solomon decoder that protects a frame's header block. For every bit of that block it takes the bit as received from the PHY and the bit as corrected by the decoder, and XORs them into the error pattern. Because the pattern comes from that XOR, a decoder core that has no error output of its own can still be used.

The pattern cannot go straight into the recursive inverse filter that follows. That filter has no self-synchronisation, and the self-synchronising FIR ahead of the decoder may still hold false errors at the start of the block. The block therefore counts consecutive error-free bits. A header block is 48 octets, and at most 8 of them can be in error, so a run of at least 40 zero bits always occurs. At the end of the first such run the FIR is known to be flushed. The block then raises a one-cycle jam that clears the inverse filter state. In that same cycle it presents the first pattern bit, and it forwards every remaining pattern bit of the block. Everything up to and including the run is dropped. If a block ends without such a run, a failure flag is raised and nothing is forwarded for that block.

Top module: `fecErrTrim`

## Requirements
- R1: Each forwarded pattern bit equals rxBit XOR fixBit of the accepted input bit it belongs to. It appears on patBit with patValid high in the clock cycle after that bit is accepted.
- R2: A block is 384 accepted bits (48 octets). Its first bit is the one presented with blkStart and inValid both high. Valid bits after the 384th bit and before the next blkStart produce no output and leave fail unchanged.
- R3: The zero-run count grows by one for each accepted bit whose error bit is 0. A 1 in the error bit sets it back to zero, and so does the start of a block.
- R4: Until 40 consecutive zero error bits have been accepted in the current block, no bit is forwarded. The 40 zero bits of the run and every bit before them are dropped.
- R5: After the first qualifying run, every later bit of the block is forwarded in order, up to and including bit 383, whether its error bit is 0 or 1.
- R6: jam is high for exactly one cycle, in the same cycle as the first forwarded bit of a block. Later runs in the same block raise no further jam. If the run ends on the last bit of the block, no bit is forwarded and no jam is raised.
- R7: If a block's last bit is accepted without a qualifying run, fail goes high in the next cycle. It stays high until the cycle after the next blkStart bit is accepted. No bit of a failed block is forwarded.
- R8: While reset (rstN low) is applied and after it is released, patValid, patBit, jam and fail are 0 until input arrives.
- R9: A blkStart in the middle of a block abandons that block and begins a new one with that bit as bit 0. The run count and bit position of the abandoned block are discarded.
- R10: Cycles with inValid low neither extend nor break a zero run, and produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| blkStart | input | 1 | Marks the first bit of a header block, qualified by inValid |
| inValid | input | 1 | rxBit and fixBit carry a bit this cycle |
| rxBit | input | 1 | Bit as received, before correction |
| fixBit | input | 1 | Same bit after decoder correction |
| patValid | output | 1 | patBit carries a forwarded error-pattern bit |
| patBit | output | 1 | Trimmed error-pattern bit for the inverse filter |
| jam | output | 1 | One-cycle pulse that clears the inverse filter state |
| fail | output | 1 | The last block ended without a 40-bit zero run |

## Verification
The blocks use several error layouts. A clean block shows the earliest possible start, at bit 40. A block with errors spaced 40 bits apart never holds a 40-bit run and ends in fail, while the same spacing widened to 41 bits triggers right after the first gap. These two tell an off-by-one in the run length apart from a correct count. Two more layouts cover the boundaries: one whose run closes exactly on the last bit, and one with errors after the jam point that must come out as ones without a second jam. Idle gaps inside a block, a blkStart in mid-block and surplus bits after a block end show that the run count is held, restarted and frozen where it should be.

// File: rtl/fecErrTrimPkg.sv
package fecErrTrimPkg;

  // Strobes from the control FSM to the datapath, one set per cycle.
  typedef struct packed {
    logic restart;  // accepted bit is bit 0 of a new block
    logic take;     // accepted bit belongs to the current block
    logic fwd;      // forward this bit's error value
    logic jam;      // this forwarded bit is the first of the block
    logic setFail;  // block ends without a qualifying run
    logic clrFail;  // new block clears a previous failure
  } trimCtrlT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // between blocks, bits ignored
    ST_HUNT  = 2'd1,  // looking for the zero run
    ST_ARMED = 2'd2,  // run found, next bit is the first forwarded one
    ST_PASS  = 2'd3   // forwarding the rest of the block
  } trimStateT;

endpackage

// File: rtl/fecErrTrimDatapath.sv
module fecErrTrimDatapath
  import fecErrTrimPkg::*;
#(
  parameter int BLOCK_OCTETS = 48,
  parameter int RUN_BITS     = 40
) (
  input  logic     clk,
  input  logic     rstN,
  input  trimCtrlT ctrl,
  input  logic     rxBit,
  input  logic     fixBit,
  output logic     errBit,
  output logic     runNear,
  output logic     cntLast,
  output logic     patValid,
  output logic     patBit,
  output logic     jam,
  output logic     fail
);

  localparam int BLOCK_BITS = BLOCK_OCTETS * 8;
  localparam int CNT_W      = $clog2(BLOCK_BITS + 1);
  localparam int RUN_W      = $clog2(RUN_BITS + 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(RUN_BITS);
  localparam logic [RUN_W-1:0] RUN_NEAR = RUN_W'(RUN_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLOCK_BITS - 1);

  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] runBase;
  logic [RUN_W-1:0] runNext;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] cntBase;

  // Error pattern: difference between received and corrected bit.
  assign errBit = rxBit ^ fixBit;

  // Registered position status; the control adjusts them for a restart.
  assign runNear = (runCnt == RUN_NEAR);
  assign cntLast = (bitCnt == CNT_LAST);

  always_comb begin
    runBase = ctrl.restart ? '0 : runCnt;
    cntBase = ctrl.restart ? '0 : bitCnt;
    if (errBit) begin
      runNext = '0;
    end else if (runBase == RUN_MAX) begin
      runNext = runBase;
    end else begin
      runNext = runBase + RUN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      bitCnt <= '0;
    end else if (ctrl.take) begin
      runCnt <= runNext;
      bitCnt <= cntBase + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patValid <= 1'b0;
      patBit   <= 1'b0;
      jam      <= 1'b0;
      fail     <= 1'b0;
    end else begin
      patValid <= ctrl.fwd;
      patBit   <= ctrl.fwd & errBit;
      jam      <= ctrl.jam;
      if (ctrl.setFail) begin
        fail <= 1'b1;
      end else if (ctrl.clrFail) begin
        fail <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fecErrTrimControl.sv
module fecErrTrimControl
  import fecErrTrimPkg::*;
#(
  parameter int BLOCK_OCTETS = 48,
  parameter int RUN_BITS     = 40
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     blkStart,
  input  logic     inValid,
  input  logic     errBit,
  input  logic     runNear,
  input  logic     cntLast,
  output trimCtrlT ctrl
);

  localparam int   BLOCK_BITS  = BLOCK_OCTETS * 8;
  localparam logic RUN_OF_ONE  = (RUN_BITS == 1);
  localparam logic BLK_OF_ONE  = (BLOCK_BITS == 1);

  trimStateT state;
  trimStateT stateNext;
  logic      hunting;
  logic      runHit;
  logic      lastHit;

  always_comb begin
    ctrl         = '0;
    ctrl.restart = inValid & blkStart;
    ctrl.take    = ctrl.restart | (inValid & (state != ST_IDLE));
    hunting      = ctrl.restart | (state == ST_HUNT);
    runHit       = ~errBit & (ctrl.restart ? RUN_OF_ONE : runNear);
    lastHit      = ctrl.restart ? BLK_OF_ONE : cntLast;
    ctrl.fwd     = ctrl.take & ~ctrl.restart &
                   ((state == ST_ARMED) | (state == ST_PASS));
    ctrl.jam     = ctrl.fwd & (state == ST_ARMED);
    ctrl.setFail = ctrl.take & lastHit & hunting & ~runHit;
    ctrl.clrFail = ctrl.restart;
  end

  always_comb begin
    stateNext = state;
    if (ctrl.take) begin
      if (lastHit) begin
        stateNext = ST_IDLE;
      end else if (hunting) begin
        stateNext = runHit ? ST_ARMED : ST_HUNT;
      end else begin
        stateNext = ST_PASS;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

endmodule

// File: rtl/fecErrTrim.sv
module fecErrTrim
  import fecErrTrimPkg::*;
#(
  parameter int BLOCK_OCTETS = 48,
  parameter int RUN_BITS     = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic blkStart,
  input  logic inValid,
  input  logic rxBit,
  input  logic fixBit,
  output logic patValid,
  output logic patBit,
  output logic jam,
  output logic fail
);

  trimCtrlT ctrl;
  logic     errBit;
  logic     runNear;
  logic     cntLast;

  fecErrTrimControl #(
    .BLOCK_OCTETS(BLOCK_OCTETS),
    .RUN_BITS    (RUN_BITS)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .blkStart(blkStart),
    .inValid (inValid),
    .errBit  (errBit),
    .runNear (runNear),
    .cntLast (cntLast),
    .ctrl    (ctrl)
  );

  fecErrTrimDatapath #(
    .BLOCK_OCTETS(BLOCK_OCTETS),
    .RUN_BITS    (RUN_BITS)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .rxBit   (rxBit),
    .fixBit  (fixBit),
    .errBit  (errBit),
    .runNear (runNear),
    .cntLast (cntLast),
    .patValid(patValid),
    .patBit  (patBit),
    .jam     (jam),
    .fail    (fail)
  );

endmodule

// File: rtl/fecErrTrimChk.sv
module fecErrTrimChk #(
  parameter int BLOCK_OCTETS = 48,
  parameter int RUN_BITS     = 40
) (
  input logic clk,
  input logic rstN,
  input logic blkStart,
  input logic inValid,
  input logic rxBit,
  input logic fixBit,
  input logic patValid,
  input logic patBit,
  input logic jam,
  input logic fail
);

  localparam int RUN_W = $clog2(RUN_BITS + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_BITS);

  logic [RUN_W-1:0] zeroRun;
  logic             runSeen;
  logic             jamSeen;
  logic             inErr;

  assign inErr = rxBit ^ fixBit;

  // Independent run tracker on the input side, per block.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroRun <= '0;
      runSeen <= 1'b0;
    end else if (inValid) begin
      if (blkStart) begin
        zeroRun <= inErr ? '0 : RUN_W'(1);
        runSeen <= 1'b0;
      end else if (inErr) begin
        zeroRun <= '0;
      end else if (zeroRun != RUN_MAX) begin
        zeroRun <= zeroRun + RUN_W'(1);
        if (zeroRun + RUN_W'(1) == RUN_MAX) runSeen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      jamSeen <= 1'b0;
    end else if (inValid && blkStart) begin
      jamSeen <= 1'b0;
    end else if (jam) begin
      jamSeen <= 1'b1;
    end
  end

  AST_PAT_IS_XOR: assert property (@(posedge clk) disable iff (!rstN)
    patValid |-> (patBit == $past(rxBit ^ fixBit))); // R1

  AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    patValid |-> $past(inValid)); // R10

  AST_TRIM_AFTER_RUN: assert property (@(posedge clk) disable iff (!rstN)
    patValid |-> runSeen); // R4

  AST_JAM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    jam |=> !jam); // R6

  AST_JAM_WITH_DATA: assert property (@(posedge clk) disable iff (!rstN)
    jam |-> patValid); // R6

  AST_JAM_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    jam |-> !jamSeen); // R6

  AST_FAIL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> !patValid); // R7

endmodule

bind fecErrTrim fecErrTrimChk #(
  .BLOCK_OCTETS(BLOCK_OCTETS),
  .RUN_BITS    (RUN_BITS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .blkStart(blkStart),
  .inValid (inValid),
  .rxBit   (rxBit),
  .fixBit  (fixBit),
  .patValid(patValid),
  .patBit  (patBit),
  .jam     (jam),
  .fail    (fail)
);

// File: tb/test_fecErrTrim.sv
module test_fecErrTrim;

  localparam int CLK_PERIOD = 10;
  localparam int BLK_BITS   = 384;
  localparam logic [15:0] NONE = 16'hFFFF;

  typedef struct packed {
    logic [15:0] period;    // periodic error spacing, 0 = none
    logic [15:0] perLimit;  // last index of periodic errors
    logic [15:0] x0;        // extra error position
    logic [15:0] x1;        // extra error position
    logic [15:0] firstFwd;  // index of first forwarded bit, 384 = none
    logic        expFail;
    logic        gaps;      // insert idle cycles
  } vecT;

  localparam int NVEC = 7;
  localparam vecT VECS [NVEC] = '{
    '{16'd0,  16'd0,   NONE,    NONE,    16'd40,  1'b0, 1'b0}, // clean block
    '{16'd0,  16'd0,   16'd10,  16'd45,  16'd86,  1'b0, 1'b1}, // run after 45
    '{16'd40, 16'd360, NONE,    NONE,    16'd384, 1'b1, 1'b0}, // 39-bit gaps only
    '{16'd41, 16'd383, NONE,    NONE,    16'd41,  1'b0, 1'b0}, // 40-bit gap
    '{16'd0,  16'd0,   16'd39,  NONE,    16'd80,  1'b0, 1'b1}, // run 40..79
    '{16'd40, 16'd320, 16'd343, NONE,    16'd384, 1'b0, 1'b0}, // run ends on last bit
    '{16'd383,16'd383, 16'd5,   16'd100, 16'd46,  1'b0, 1'b1}  // errors after jam
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic blkStart = 1'b0;
  logic inValid = 1'b0;
  logic rxBit = 1'b0;
  logic fixBit = 1'b0;
  logic patValid, patBit, jam, fail;

  int nTests = 0;
  int nFails = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fecErrTrim i_fecErrTrim (
    .clk(clk), .rstN(rstN), .blkStart(blkStart), .inValid(inValid),
    .rxBit(rxBit), .fixBit(fixBit), .patValid(patValid), .patBit(patBit),
    .jam(jam), .fail(fail)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic isErr(vecT v, int i);
    logic e;
    e = (i == int'(v.x0)) || (i == int'(v.x1));
    if (v.period != 0 && i <= int'(v.perLimit) && (i % int'(v.period)) == 0)
      e = 1'b1;
    return e;
  endfunction

  // One accepted bit; outputs sampled 1 time unit after the capturing edge.
  task automatic driveBit(input logic start, input logic err);
    @(negedge clk);
    blkStart = start;
    inValid  = 1'b1;
    rxBit    = lfsr[0];
    fixBit   = lfsr[0] ^ err;
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    @(posedge clk);
    #1;
  endtask

  task automatic idleCycle();
    @(negedge clk);
    blkStart = 1'b0;
    inValid  = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic runBlock(input vecT v);
    for (int i = 0; i < BLK_BITS; i++) begin
      if (v.gaps && (i % 7) == 3) begin
        idleCycle();
        chk(!patValid && !jam, "R10", "idle output", int'(patValid), 0);
      end
      driveBit(i == 0, isErr(v, i));
      begin
        logic ev, eb, ej, ef;
        ev = (i >= int'(v.firstFwd));
        eb = ev & isErr(v, i);
        ej = (i == int'(v.firstFwd));
        ef = (i == BLK_BITS - 1) ? v.expFail : 1'b0;
        if (patValid !== ev)
          chk(1'b0, ev ? "R5" : "R4", "patValid", int'(patValid), int'(ev));
        else if (patBit !== eb)
          chk(1'b0, "R1", "patBit", int'(patBit), int'(eb));
        else if (jam !== ej)
          chk(1'b0, "R6", "jam", int'(jam), int'(ej));
        else if (fail !== ef)
          chk(1'b0, "R7", "fail", int'(fail), int'(ef));
        else
          chk(1'b1, "R1", "bit", 0, 0);
      end
    end
    @(negedge clk);
    inValid  = 1'b0;
    blkStart = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nTests++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(!patValid && !patBit && !jam && !fail, "R8", "outputs in reset",
        int'({patValid, patBit, jam, fail}), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(!patValid && !patBit && !jam && !fail, "R8", "outputs after reset",
        int'({patValid, patBit, jam, fail}), 0);

    // Table of blocks: R1 R3 R4 R5 R6 R7 R10
    for (int k = 0; k < NVEC; k++) begin
      runBlock(VECS[k]);
    end

    // R2: surplus bits after a block end are ignored
    for (int i = 0; i < 5; i++) begin
      driveBit(1'b0, 1'b1);
      chk(!patValid && !jam, "R2", "surplus bit output", int'(patValid), 0);
      chk(!fail, "R2", "surplus fail", int'(fail), 0);
    end

    // R7: failure is held across idle time until the next block
    runBlock(VECS[2]);
    for (int i = 0; i < 6; i++) begin
      idleCycle();
      chk(fail == 1'b1, "R7", "fail held", int'(fail), 1);
    end

    // R9 / R3: abandoned block, zero run restarts from the new blkStart
    for (int i = 0; i < 30; i++) begin
      driveBit(i == 0, 1'b0);
      chk(!patValid, "R9", "partial block output", int'(patValid), 0);
    end
    runBlock(VECS[0]);

    // R9: restart while forwarding
    for (int i = 0; i < 60; i++) begin
      driveBit(i == 0, 1'b0);
    end
    chk(patValid == 1'b1, "R9", "forwarding before restart", int'(patValid), 1);
    runBlock(VECS[4]);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule